// File: doc/BRIEF.md
# Bit Scatter/Gather Unit

This unit moves bits between a source word and positions chosen by a mask word, one mask bit per clock. In scatter mode, the lowest source bits are placed, in order, at the bit positions where the mask holds a one. In gather mode, the source bits found at the mask's one positions are packed, in order, into the low end of the result. Every result bit that no step writes reads as zero.

A request is given by pulsing `start_i` with the operands and mode present. The unit captures them and raises `busy_o`. Each busy cycle it locates the lowest one left in its working copy of the mask, moves one bit, and clears that mask bit. When the working mask is empty, it drops `busy_o`, pulses `done_o` for one cycle and keeps `result_o` until the next accepted request. The run time depends only on how many ones the mask holds.

Top module: `bit_gather_scatter`

## Requirements
- R1: Each busy cycle in which the working mask is non-zero clears exactly one mask bit, the lowest set one, and sets no other bit.
- R2: With `mode_i` = 0 (scatter), on step k (counting from 0), source bit k is written to the result at the index of the lowest remaining mask bit.
- R3: With `mode_i` = 1 (gather), on step k (counting from 0), the source bit at the index of the lowest remaining mask bit is written to result bit k.
- R4: The result is cleared when a request is accepted, so result bits that no step writes are 0, whatever the source bits outside the consumed range hold.
- R5: An all-zero mask gives a zero result, and `done_o` rises on the first clock edge after the accepting edge.
- R6: `done_o` rises exactly popcount(mask)+1 clock edges after the edge that accepts the request, stays high for one cycle, and `busy_o` is high from the accepting edge until `done_o` rises.
- R7: A `start_i` seen while `busy_o` is high is ignored. The operands and mode in use, the result and the timing of the running request do not change.
- R8: After reset, `busy_o`, `done_o` and `result_o` are 0. After `done_o`, `result_o` keeps its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse, accepted only when idle |
| mode_i | input | 1 | 0 = scatter, 1 = gather |
| src_i | input | W | Source word |
| mask_i | input | W | Position mask |
| busy_o | output | 1 | A request is being processed |
| done_o | output | 1 | One-cycle pulse: result is final |
| result_o | output | W | Scatter/gather result |

## Verification
The bound checker covers the per-cycle rules on every cycle. It checks that the working mask loses exactly its lowest one per busy step and never gains a bit, and that an empty mask ends the run on the next edge. It also checks that `done_o` is a single-cycle pulse seen only while idle, that a start during a run does not disturb the step count, and that the result stays fixed while the unit is idle. Whether the right bits land in the right places in each mode, the exact end-to-end latency for a given mask, and the all-zero and all-one mask cases can only be shown by the bench. It compares finished results and measured latencies against its own model for chosen and pseudo-random operands.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic {
    BGS_SCATTER = 1'b0,
    BGS_GATHER  = 1'b1
  } bgs_mode_e;
endpackage

// File: rtl/bgs_lsb_enc.sv
// Priority encoder: index of the lowest set bit of vec_i.
module bgs_lsb_enc #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/bgs_ctrl.sv
// Sequencer: accepts requests when idle, counts steps, issues done pulse.
module bgs_ctrl #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          rem_empty_i,
  output logic          accept_o,
  output logic          step_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  assign accept_o = start_i && !busy_o;
  assign step_o   = busy_o && !rem_empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt_o  <= '0;
      end else if (step_o) begin
        cnt_o  <= cnt_o + 1'b1;
      end else if (busy_o) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bgs_route.sv
// Chooses the write position and written bit for one step.
module bgs_route #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  bgs_pkg::bgs_mode_e mode_i,
  input  logic [W-1:0]       src_i,
  input  logic [IW-1:0]      low_idx_i,
  input  logic [IW-1:0]      step_idx_i,
  output logic [IW-1:0]      wr_pos_o,
  output logic               wr_bit_o
);
  always_comb begin
    if (mode_i == bgs_pkg::BGS_SCATTER) begin
      wr_pos_o = low_idx_i;
      wr_bit_o = src_i[step_idx_i];
    end else begin
      wr_pos_o = step_idx_i;
      wr_bit_o = src_i[low_idx_i];
    end
  end
endmodule

// File: rtl/bit_gather_scatter.sv
module bit_gather_scatter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]       src_q;
  logic [W-1:0]       rem_q;
  bgs_pkg::bgs_mode_e mode_q;
  logic [IW-1:0]      low_idx;
  logic               rem_any;
  logic               accept;
  logic               step;
  logic [CW-1:0]      cnt;
  logic [IW-1:0]      wr_pos;
  logic               wr_bit;

  bgs_lsb_enc #(.W(W), .IW(IW)) u_enc (
    .vec_i (rem_q),
    .idx_o (low_idx),
    .any_o (rem_any)
  );

  bgs_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rem_empty_i (!rem_any),
    .accept_o    (accept),
    .step_o      (step),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cnt_o       (cnt)
  );

  bgs_route #(.W(W), .IW(IW)) u_route (
    .mode_i     (mode_q),
    .src_i      (src_q),
    .low_idx_i  (low_idx),
    .step_idx_i (cnt[IW-1:0]),
    .wr_pos_o   (wr_pos),
    .wr_bit_o   (wr_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      rem_q    <= '0;
      mode_q   <= bgs_pkg::BGS_SCATTER;
      result_o <= '0;
    end else if (accept) begin
      src_q    <= src_i;
      rem_q    <= mask_i;
      mode_q   <= bgs_pkg::bgs_mode_e'(mode_i);
      result_o <= '0;
    end else if (step) begin
      rem_q            <= rem_q & (rem_q - 1'b1);
      result_o[wr_pos] <= wr_bit;
    end
  end
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  result_o,
  input logic [W-1:0]  rem,
  input logic [CW-1:0] cnt
);
  AST_REM_DROPS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (busy_o && rem != '0) |=> (($countones(rem) + 1 == $countones($past(rem))) && ((rem & ~$past(rem)) == '0) && (($past(rem) & ~rem) == ($past(rem) & (~$past(rem) + 1'b1))))); // R1

  AST_EMPTY_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (busy_o && rem == '0) |=> (done_o && !busy_o)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt <= CW'(W))); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && rem != '0) |=> (busy_o && cnt == CW'($past(cnt) + 1'b1))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(result_o)); // R8
endmodule

bind bit_gather_scatter bgs_checker #(.W(W)) u_bgs_checker (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .rem      (rem_q),
  .cnt      (cnt)
);

// File: tb/bit_gather_scatter_bench.sv
`timescale 1ns/1ps
module bit_gather_scatter_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] src_i = '0;
  logic [W-1:0] mask_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] result_o;

  always #4 clk = ~clk;

  bit_gather_scatter #(.W(W)) u_bit_gather_scatter (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .src_i    (src_i),
    .mask_i   (mask_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_done = 0;
  int n_issued = 0;
  bit finished = 1'b0;

  logic [W-1:0] exp_q[$];
  int           lat_q[$];
  int           st_q[$];
  string        tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_scatter(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        r[i] = s[k];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_gather(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        r[k] = s[i];
        k++;
      end
    end
    return r;
  endfunction

  // Monitor: pops the scoreboard whenever the unit reports completion.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected done", W'(1), W'(0));
      end else begin
        logic [W-1:0] e;
        int l;
        int s;
        string t;
        e = exp_q.pop_front();
        l = lat_q.pop_front();
        s = st_q.pop_front();
        t = tag_q.pop_front();
        chk(result_o === e, t, result_o, e);
        chk((cyc - s) == l, {"R6 latency ", t}, W'(cyc - s), W'(l));
      end
      n_done++;
    end
  end

  task automatic run_op(input logic m, input logic [W-1:0] s, input logic [W-1:0] msk,
                        input string tag, input bit poke);
    logic [W-1:0] e;
    int pc;
    e  = m ? ref_gather(s, msk) : ref_scatter(s, msk);
    pc = $countones(msk);
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = m;
    src_i   = s;
    mask_i  = msk;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    lat_q.push_back(pc + 1);
    st_q.push_back(cyc);
    tag_q.push_back(tag);
    n_issued++;
    @(negedge clk);
    start_i = 1'b0;
    if (pc > 0) chk(busy_o === 1'b1, "R6 busy during run", W'(busy_o), W'(1));
    if (poke && busy_o) begin
      // R7: new request while busy must be ignored
      start_i = 1'b1;
      mode_i  = ~m;
      src_i   = ~s;
      mask_i  = ~msk;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (n_done == n_issued);
    repeat (3) @(negedge clk);
    chk(result_o === e, {"R8 hold ", tag}, result_o, e);
  endtask

  initial begin
    logic [W-1:0] lfsr;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy_o === 1'b0, "R8 reset busy", W'(busy_o), W'(0));
    chk(done_o === 1'b0, "R8 reset done", W'(done_o), W'(0));
    chk(result_o === '0, "R8 reset result", result_o, '0);

    run_op(1'b0, 32'hFFFF_FFFF, 32'h8000_0001, "R2 scatter ends", 1'b0);
    run_op(1'b0, 32'h0000_0005, 32'h0000_F0F0, "R2 scatter nibbles", 1'b0);
    run_op(1'b1, 32'hDEAD_BEEF, 32'hFF00_FF00, "R3 gather bytes", 1'b0);
    run_op(1'b1, 32'h8000_0001, 32'h8000_0001, "R3 gather ends", 1'b0);
    run_op(1'b0, 32'hFFFF_FFF0, 32'h0F0F_0000, "R4 scatter unused src", 1'b0);
    run_op(1'b1, 32'hFFFF_FFFF, 32'h0000_00F0, "R4 gather zero fill", 1'b0);
    run_op(1'b0, 32'h1234_5678, 32'h0000_0000, "R5 scatter zero mask", 1'b0);
    run_op(1'b1, 32'h1234_5678, 32'h0000_0000, "R5 gather zero mask", 1'b0);
    run_op(1'b0, 32'hA5C3_0F96, 32'hFFFF_FFFF, "R6 scatter full mask", 1'b0);
    run_op(1'b1, 32'hA5C3_0F96, 32'hFFFF_FFFF, "R6 gather full mask", 1'b0);
    run_op(1'b0, 32'h0000_00B7, 32'h00F0_0F0F, "R7 scatter poke", 1'b1);
    run_op(1'b1, 32'hC0FF_EE11, 32'h0F0F_3300, "R7 gather poke", 1'b1);

    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] s;
      logic [W-1:0] mk;
      lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      s = lfsr;
      lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mk = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      run_op(i[0], s, mk, i[0] ? "R3 gather random" : "R2 scatter random", i[1]);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", n_done, n_issued);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule